// File: doc/BRIEF.md
# Keyed Configuration Port Controller

This block is the configuration front end of a multi-function I/O controller on a byte-wide I/O bus. It watches two adjacent bus addresses: an index port and, one address above it, a data port. The configuration registers are locked at reset. A host opens them by writing an entry key to the index port twice in a row, and locks them again with a one-byte exit key.

While the registers are open, each index-port write selects a register number. Data-port reads and writes then reach that register. Register numbers below 0x30 are global: the logical-device selector and a pin-routing register. Numbers from 0x30 upward are banked. They act on the register set of whichever logical device the selector names. Each device has an enable bit and a 16-bit I/O base, and all of them are brought out as decoded outputs, together with a routing pin for the first serial port.

Top module: `keyed_cfg_port`

## Requirements
- R1: After reset the block is locked (`cfg_active` low), the route output is low, and every device is disabled with base 0x0000.
- R2: The block unlocks only after two consecutive index-port writes of 0x87. Any other index-port write made before the second 0x87 returns the key progress to the start.
- R3: While unlocked, an index-port write of 0xAA locks the block in the cycle after the write.
- R4: While locked, data-port writes change no register or output, and data-port reads return 0xFF.
- R5: With `alt_pair_sel` low, the index and data ports are 0x4E and 0x4F. With it high, they are 0x2E and 0x2F, and the other pair does not respond.
- R6: Index 0x07 holds the logical-device number (low three bits) and reads back as the number held.
- R7: Bit 0 of index 0x30 is the enable of the selected device, shown on `dev_enable[n]`. It reads back as 0x00 or 0x01.
- R8: Index 0x60 holds the high byte and 0x61 the low byte of the selected device's base, shown on `dev_base[16n +: 16]`.
- R9: Index 0x2A is a global byte. Its bit 6 drives `pin_route_uart_a`, so writing 0x40 routes the pins to serial port A. It reads back the same whatever device is selected.
- R10: While unlocked, an index-port read returns the register index last selected.
- R11: Unimplemented indexes, global or banked, read 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| alt_pair_sel | input | 1 | Strap input: 0 selects the 0x4E/0x4F port pair, 1 selects 0x2E/0x2F |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 16 | I/O address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data (combinational), 0xFF when nothing answers |
| cfg_active | output | 1 | High while configuration access is unlocked |
| pin_route_uart_a | output | 1 | Routes the shared pin group to serial port A |
| dev_enable | output | 8 | Enable bit of each logical device |
| dev_base | output | 128 | 16-bit I/O base of each device, device n at bits 16n+15:16n |

## Verification
Directed sequences separate a double entry key from a single key and from a key pair broken by another index write. They also separate writes made while locked from writes made while unlocked, and the two port pairs selected by the strap. Banked writes are made under several device numbers, so that a write landing on the wrong device, or a global register wrongly banked, shows on the outputs. A long random run then mixes entry keys, exit keys, register selects, data writes and reads. Every output and read value is compared with a bench model, which tests the ordering of key progress against index selection.

// File: rtl/keyed_cfg_pkg.sv
package keyed_cfg_pkg;
   typedef enum logic [1:0] {
      KS_LOCKED = 2'd0,
      KS_HALF   = 2'd1,
      KS_OPEN   = 2'd2
   } key_state_e;

   localparam logic [7:0] IDX_LDN        = 8'h07;
   localparam logic [7:0] IDX_ROUTE      = 8'h2A;
   localparam logic [7:0] IDX_BANK_START = 8'h30;
   localparam logic [7:0] IDX_ENABLE     = 8'h30;
   localparam logic [7:0] IDX_BASE_HI    = 8'h60;
   localparam logic [7:0] IDX_BASE_LO    = 8'h61;
endpackage

// File: rtl/keyed_cfg_unlock.sv
module keyed_cfg_unlock
   import keyed_cfg_pkg::*;
#(
   parameter logic [7:0] ENTRY_KEY = 8'h87,
   parameter logic [7:0] EXIT_KEY  = 8'hAA
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       idx_wr,
   input  logic [7:0] wdata,
   output logic       open,
   output logic [7:0] index
);
   key_state_e state_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= KS_LOCKED;
         index   <= 8'h00;
      end else if (idx_wr) begin
         case (state_q)
            KS_LOCKED: state_q <= (wdata == ENTRY_KEY) ? KS_HALF : KS_LOCKED;
            KS_HALF:   state_q <= (wdata == ENTRY_KEY) ? KS_OPEN : KS_LOCKED;
            KS_OPEN: begin
               if (wdata == EXIT_KEY) state_q <= KS_LOCKED;
               else                   index   <= wdata;
            end
            default:   state_q <= KS_LOCKED;
         endcase
      end
   end

   assign open = (state_q == KS_OPEN);
endmodule

// File: rtl/keyed_cfg_global.sv
module keyed_cfg_global
   import keyed_cfg_pkg::*;
#(
   parameter int LDN_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [7:0]       idx,
   input  logic [7:0]       wdata,
   output logic [LDN_W-1:0] ldn,
   output logic [7:0]       route_reg,
   output logic [7:0]       rd_val
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ldn       <= '0;
         route_reg <= 8'h00;
      end else if (wr) begin
         if (idx == IDX_LDN)   ldn       <= wdata[LDN_W-1:0];
         if (idx == IDX_ROUTE) route_reg <= wdata;
      end
   end

   always_comb begin
      if (idx == IDX_LDN)        rd_val = 8'(ldn);
      else if (idx == IDX_ROUTE) rd_val = route_reg;
      else                       rd_val = 8'h00;
   end
endmodule

// File: rtl/keyed_cfg_bank.sv
module keyed_cfg_bank
   import keyed_cfg_pkg::*;
#(
   parameter int NDEV   = 8,
   parameter int LDN_W  = 3,
   parameter int BASE_W = 16
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   wr,
   input  logic [7:0]             idx,
   input  logic [7:0]             wdata,
   input  logic [LDN_W-1:0]       ldn,
   output logic [NDEV-1:0]        en,
   output logic [NDEV*BASE_W-1:0] base_flat,
   output logic [7:0]             rd_val
);
   localparam int HI_W = BASE_W - 8;

   logic [NDEV-1:0][BASE_W-1:0] base_q;

   for (genvar g = 0; g < NDEV; g++) begin : g_dev
      logic sel;
      assign sel = wr && (ldn == LDN_W'(g));
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            en[g]     <= 1'b0;
            base_q[g] <= '0;
         end else if (sel) begin
            if (idx == IDX_ENABLE)  en[g]                  <= wdata[0];
            if (idx == IDX_BASE_HI) base_q[g][BASE_W-1:8]  <= wdata[HI_W-1:0];
            if (idx == IDX_BASE_LO) base_q[g][7:0]         <= wdata;
         end
      end
   end

   assign base_flat = base_q;

   always_comb begin
      if (idx == IDX_ENABLE)       rd_val = {7'b0, en[ldn]};
      else if (idx == IDX_BASE_HI) rd_val = 8'(base_q[ldn][BASE_W-1:8]);
      else if (idx == IDX_BASE_LO) rd_val = base_q[ldn][7:0];
      else                         rd_val = 8'h00;
   end
endmodule

// File: rtl/keyed_cfg_port.sv
module keyed_cfg_port
   import keyed_cfg_pkg::*;
#(
   parameter int          ADDR_W    = 16,
   parameter int          NDEV      = 8,
   parameter int          BASE_W    = 16,
   parameter int          ROUTE_BIT = 6,
   parameter logic [15:0] PRI_IDX   = 16'h004E,
   parameter logic [15:0] ALT_IDX   = 16'h002E,
   parameter logic [7:0]  ENTRY_KEY = 8'h87,
   parameter logic [7:0]  EXIT_KEY  = 8'hAA
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   alt_pair_sel,
   input  logic                   bus_wr,
   input  logic                   bus_rd,
   input  logic [ADDR_W-1:0]      bus_addr,
   input  logic [7:0]             bus_wdata,
   output logic [7:0]             bus_rdata,
   output logic                   cfg_active,
   output logic                   pin_route_uart_a,
   output logic [NDEV-1:0]        dev_enable,
   output logic [NDEV*BASE_W-1:0] dev_base
);
   localparam int LDN_W = $clog2(NDEV);

   if (NDEV < 2 || NDEV > 256 || (NDEV & (NDEV - 1)) != 0)
      $error("NDEV must be a power of two from 2 to 256");
   if (BASE_W < 9 || BASE_W > 16)
      $error("BASE_W must lie in 9..16");
   if (ROUTE_BIT < 0 || ROUTE_BIT > 7)
      $error("ROUTE_BIT must select a bit of a byte");
   if (ADDR_W < 8 || ADDR_W > 16)
      $error("ADDR_W must lie in 8..16");

   logic [ADDR_W-1:0] idx_addr, dat_addr;
   logic              idx_hit, dat_hit, open, cfg_wr;
   logic [7:0]        index, glob_rd, bank_rd, route_reg, cfg_rd;
   logic [LDN_W-1:0]  ldn;

   assign idx_addr = alt_pair_sel ? ADDR_W'(ALT_IDX) : ADDR_W'(PRI_IDX);
   assign dat_addr = idx_addr + ADDR_W'(1);
   assign idx_hit  = (bus_addr == idx_addr);
   assign dat_hit  = (bus_addr == dat_addr);
   assign cfg_wr   = bus_wr && dat_hit && open;

   keyed_cfg_unlock #(.ENTRY_KEY(ENTRY_KEY), .EXIT_KEY(EXIT_KEY)) u_unlock (
      .clk(clk), .rst_n(rst_n), .idx_wr(bus_wr && idx_hit),
      .wdata(bus_wdata), .open(open), .index(index));

   keyed_cfg_global #(.LDN_W(LDN_W)) u_global (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .idx(index), .wdata(bus_wdata),
      .ldn(ldn), .route_reg(route_reg), .rd_val(glob_rd));

   keyed_cfg_bank #(.NDEV(NDEV), .LDN_W(LDN_W), .BASE_W(BASE_W)) u_bank (
      .clk(clk), .rst_n(rst_n), .wr(cfg_wr), .idx(index), .wdata(bus_wdata),
      .ldn(ldn), .en(dev_enable), .base_flat(dev_base), .rd_val(bank_rd));

   assign cfg_rd = (index >= IDX_BANK_START) ? bank_rd : glob_rd;

   always_comb begin
      if (bus_rd && open && idx_hit)      bus_rdata = index;
      else if (bus_rd && open && dat_hit) bus_rdata = cfg_rd;
      else                                bus_rdata = 8'hFF;
   end

   assign cfg_active       = open;
   assign pin_route_uart_a = route_reg[ROUTE_BIT];
endmodule

// File: rtl/keyed_cfg_port_chk.sv
module keyed_cfg_port_chk #(
   parameter int          ADDR_W    = 16,
   parameter int          NDEV      = 8,
   parameter int          BASE_W    = 16,
   parameter logic [15:0] PRI_IDX   = 16'h004E,
   parameter logic [15:0] ALT_IDX   = 16'h002E,
   parameter logic [7:0]  ENTRY_KEY = 8'h87,
   parameter logic [7:0]  EXIT_KEY  = 8'hAA
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   alt_pair_sel,
   input logic                   bus_wr,
   input logic                   bus_rd,
   input logic [ADDR_W-1:0]      bus_addr,
   input logic [7:0]             bus_wdata,
   input logic [7:0]             bus_rdata,
   input logic                   cfg_active,
   input logic                   pin_route_uart_a,
   input logic [NDEV-1:0]        dev_enable,
   input logic [NDEV*BASE_W-1:0] dev_base
);
   logic [ADDR_W-1:0] c_idx, c_dat;
   logic              c_idx_wr, c_dat_wr;

   assign c_idx    = alt_pair_sel ? ADDR_W'(ALT_IDX) : ADDR_W'(PRI_IDX);
   assign c_dat    = c_idx + ADDR_W'(1);
   assign c_idx_wr = bus_wr && (bus_addr == c_idx);
   assign c_dat_wr = bus_wr && (bus_addr == c_dat);

   assert_locked_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!cfg_active && bus_rd && bus_addr == c_dat) |-> bus_rdata == 8'hFF);

   assert_locked_no_effect_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_active |=> ($stable(dev_enable) && $stable(dev_base) && $stable(pin_route_uart_a)));

   assert_exit_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_active && c_idx_wr && bus_wdata == EXIT_KEY) |=> !cfg_active);

   assert_entry_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_active) |-> $past(c_idx_wr && bus_wdata == ENTRY_KEY));

   assert_write_path_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !c_dat_wr |=> ($stable(dev_enable) && $stable(dev_base)));

   assert_one_device_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(dev_enable ^ $past(dev_enable)) <= 1);

   assert_route_path_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !c_dat_wr |=> $stable(pin_route_uart_a));
endmodule

bind keyed_cfg_port keyed_cfg_port_chk #(
   .ADDR_W(ADDR_W), .NDEV(NDEV), .BASE_W(BASE_W), .PRI_IDX(PRI_IDX),
   .ALT_IDX(ALT_IDX), .ENTRY_KEY(ENTRY_KEY), .EXIT_KEY(EXIT_KEY)
) u_chk (
   .clk(clk), .rst_n(rst_n), .alt_pair_sel(alt_pair_sel), .bus_wr(bus_wr),
   .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
   .bus_rdata(bus_rdata), .cfg_active(cfg_active),
   .pin_route_uart_a(pin_route_uart_a), .dev_enable(dev_enable),
   .dev_base(dev_base));

// File: tb/keyed_cfg_port_test.sv
module keyed_cfg_port_test;
   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         alt_pair_sel = 1'b0;
   logic         bus_wr = 1'b0;
   logic         bus_rd = 1'b0;
   logic [15:0]  bus_addr = 16'h0;
   logic [7:0]   bus_wdata = 8'h0;
   logic [7:0]   bus_rdata;
   logic         cfg_active;
   logic         pin_route_uart_a;
   logic [7:0]   dev_enable;
   logic [127:0] dev_base;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   keyed_cfg_port uut (
      .clk(clk), .rst_n(rst_n), .alt_pair_sel(alt_pair_sel), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .cfg_active(cfg_active),
      .pin_route_uart_a(pin_route_uart_a), .dev_enable(dev_enable),
      .dev_base(dev_base));

   // bench model: 0 locked, 1 one key seen, 2 unlocked
   int          ms = 0;
   logic [7:0]  mi = 8'h00;
   logic [2:0]  mldn = 3'd0;
   logic [7:0]  mroute = 8'h00;
   logic        men [8];
   logic [15:0] mbase [8];

   function automatic logic [15:0] idx_port();
      return alt_pair_sel ? 16'h002E : 16'h004E;
   endfunction

   function automatic logic [7:0] model_cfg();
      case (mi)
         8'h07:   return {5'b0, mldn};
         8'h2A:   return mroute;
         8'h30:   return {7'b0, men[mldn]};
         8'h60:   return mbase[mldn][15:8];
         8'h61:   return mbase[mldn][7:0];
         default: return 8'h00;
      endcase
   endfunction

   function automatic logic [7:0] model_read(logic [15:0] a);
      if (ms == 2 && a == idx_port()) return mi;
      if (ms == 2 && a == idx_port() + 16'd1) return model_cfg();
      return 8'hFF;
   endfunction

   task automatic model_write(logic [15:0] a, logic [7:0] v);
      if (a == idx_port()) begin
         if (ms != 2) ms = (v == 8'h87) ? ms + 1 : 0;
         else if (v == 8'hAA) ms = 0;
         else mi = v;
      end else if (a == idx_port() + 16'd1 && ms == 2) begin
         case (mi)
            8'h07: mldn = v[2:0];
            8'h2A: mroute = v;
            8'h30: men[mldn] = v[0];
            8'h60: mbase[mldn][15:8] = v;
            8'h61: mbase[mldn][7:0] = v;
            default: ;
         endcase
      end
   endtask

   task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic check_outputs(string tag);
      chk({tag, " cfg_active"}, 16'(cfg_active), 16'(ms == 2));
      chk({tag, " R9 route"}, 16'(pin_route_uart_a), 16'(mroute[6]));
      for (int d = 0; d < 8; d++) begin
         chk({tag, " R7 enable"}, 16'(dev_enable[d]), 16'(men[d]));
         chk({tag, " R8 base"}, dev_base[d*16 +: 16], mbase[d]);
      end
   endtask

   task automatic wr(logic [15:0] a, logic [7:0] v);
      @(negedge clk);
      bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      model_write(a, v);
   endtask

   task automatic rd(logic [15:0] a, string tag);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1;
      chk(tag, 16'(bus_rdata), 16'(model_read(a)));
      bus_rd = 1'b0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int d = 0; d < 8; d++) begin men[d] = 1'b0; mbase[d] = 16'h0; end
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check_outputs("R1 reset");
      rd(16'h004F, "R4 locked read");

      // R2: single key, broken pair, then a valid pair
      wr(16'h004E, 8'h87);
      chk("R2 single key", 16'(cfg_active), 16'h0);
      wr(16'h004E, 8'h55);
      wr(16'h004E, 8'h87);
      chk("R2 broken pair", 16'(cfg_active), 16'h0);
      wr(16'h004E, 8'h87);
      chk("R2 unlocked", 16'(cfg_active), 16'h1);

      // R6 R7 R8 R10
      wr(16'h004E, 8'h07); wr(16'h004F, 8'h03);
      rd(16'h004F, "R6 ldn readback");
      wr(16'h004E, 8'h30); wr(16'h004F, 8'h01);
      wr(16'h004E, 8'h60); wr(16'h004F, 8'h12);
      wr(16'h004E, 8'h61); wr(16'h004F, 8'h34);
      check_outputs("R7 R8 device3");
      chk("R8 base3", dev_base[3*16 +: 16], 16'h1234);
      rd(16'h004E, "R10 index readback");
      wr(16'h004E, 8'h07); wr(16'h004F, 8'h05);
      wr(16'h004E, 8'h30); wr(16'h004F, 8'hFE);
      rd(16'h004F, "R7 enable bit0 only");
      wr(16'h004E, 8'h60); wr(16'h004F, 8'hAB);
      check_outputs("R8 device5");

      // R9 global, not banked
      wr(16'h004E, 8'h2A); wr(16'h004F, 8'h40);
      chk("R9 route set", 16'(pin_route_uart_a), 16'h1);
      wr(16'h004E, 8'h07); wr(16'h004F, 8'h01);
      wr(16'h004E, 8'h2A);
      rd(16'h004F, "R9 global under ldn1");

      // R11 unimplemented
      wr(16'h004E, 8'h10); wr(16'h004F, 8'h5A);
      rd(16'h004F, "R11 global hole");
      wr(16'h004E, 8'h45); wr(16'h004F, 8'h77);
      rd(16'h004F, "R11 banked hole");
      check_outputs("R11 no effect");

      // R3 exit, R4 locked write ignored
      wr(16'h004E, 8'h30);
      wr(16'h004E, 8'hAA);
      chk("R3 locked", 16'(cfg_active), 16'h0);
      wr(16'h004E, 8'h07); wr(16'h004E, 8'h05);
      wr(16'h004F, 8'h01);
      check_outputs("R4 locked write");
      rd(16'h004F, "R4 locked read");
      rd(16'h004E, "R4 locked index read");

      // R5 alternate pair
      alt_pair_sel = 1'b1;
      wr(16'h004E, 8'h87); wr(16'h004E, 8'h87);
      chk("R5 old pair deaf", 16'(cfg_active), 16'h0);
      wr(16'h002E, 8'h87); wr(16'h002E, 8'h87);
      chk("R5 alt unlock", 16'(cfg_active), 16'h1);
      wr(16'h002E, 8'h07); wr(16'h002F, 8'h02);
      rd(16'h002F, "R5 alt data port");
      rd(16'h004F, "R5 old data port");
      wr(16'h002E, 8'hAA);
      alt_pair_sel = 1'b0;
      check_outputs("R5 after exit");

      // random mix, R2 R3 R6 R7 R8 R9 R10 R11 against the model
      for (int n = 0; n < 4000; n++) begin
         int kind;
         logic [7:0] v;
         kind = int'($urandom_range(0, 9));
         case ($urandom_range(0, 7))
            0, 1:    v = 8'h87;
            2:       v = 8'hAA;
            3:       v = 8'h07;
            4:       v = 8'h30;
            5:       v = ($urandom_range(0, 1) != 0) ? 8'h60 : 8'h61;
            6:       v = 8'h2A;
            default: v = 8'($urandom);
         endcase
         if (kind < 4) wr(16'h004E, v);
         else if (kind < 7) wr(16'h004F, 8'($urandom));
         else if (kind < 9) rd(16'h004F, "R6 R7 R8 R9 R11 random read");
         else rd(16'h004E, "R10 random index read");
         if (kind < 7) check_outputs("R2 R3 random");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule